// File: doc/BRIEF.md
# Non-Pipelined Local Bus Cycle Sequencer

This block runs processor-side cycles on a 32-bit local bus that has no address pipelining. A requester offers one aligned transfer at a time: a doubleword address, four active-low byte enables, a direction flag and write data. The sequencer launches the cycle with an address strobe and keeps the cycle open until the bus slave pulls its active-low ready input low. It then returns the read data and a single-clock completion pulse.

Each cycle passes through three phases: idle, an address phase of exactly one clock, and a data phase that lasts until ready is seen low. The shortest cycle therefore takes two clocks. When another request is waiting as a cycle ends, the sequencer goes straight from the data phase into the next address phase, with no idle clock in between. Misaligned transfers must be split before they reach this block.

`req_accept` is combinational. It depends on the phase register and on `bus_ready_n`. A request counts as taken on any rising edge where both `req_valid` and `req_accept` are high.

Top module: `lbus_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block returns to idle. After that edge `bus_ads_n` is 1, `rsp_done` is 0, and `bus_addr`, `bus_be_n`, `bus_wr`, `bus_wdata` and `rsp_rdata` are all zero.
- R2: In idle, the block starts an address phase on the next clock if `req_valid` is high. If `req_valid` is low it stays idle.
- R3: `bus_ads_n` is active low. It is 0 during the address phase only and is never low on two clocks in a row.
- R4: The address phase always lasts one clock and is followed by the data phase, whatever `bus_ready_n` and `req_valid` are.
- R5: In the data phase, each edge that samples `bus_ready_n` high adds a wait clock. The block stays in the data phase, and `bus_addr`, `bus_be_n`, `bus_wr` and `bus_wdata` do not change.
- R6: When the data phase ends (ready sampled low) while `req_valid` is high, the next clock is an address phase that carries the new request.
- R7: When the data phase ends while `req_valid` is low, the block returns to idle.
- R8: On the clock after a data phase ends, `rsp_done` is 1 for exactly one clock.
  - For a read (`bus_wr` = 0), `rsp_rdata` then shows the `bus_rdata` value sampled at the ending edge.
  - For a write, `rsp_rdata` keeps its previous value.
- R9: `req_accept` is 1 exactly in idle, or in the data phase while `bus_ready_n` is 0. Request fields offered at any other time do not reach the bus outputs.
- R10: With requests always pending and ready always low, cycles run back to back at two clocks each: `bus_ads_n` goes low on every second clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A transfer is offered |
| req_addr | input | 30 | Doubleword address of the transfer |
| req_be_n | input | 4 | Active-low byte enables |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| req_accept | output | 1 | Request is taken on this edge if valid |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 32 | Read data of the last completed read |
| bus_ads_n | output | 1 | Active-low address strobe |
| bus_addr | output | 30 | Bus doubleword address |
| bus_be_n | output | 4 | Bus active-low byte enables |
| bus_wr | output | 1 | Bus direction, 1 = write |
| bus_wdata | output | 32 | Bus write data |
| bus_ready_n | input | 1 | Active-low cycle-end input from the slave |
| bus_rdata | input | 32 | Bus read data |

## Verification
The hardest case to reach from the ports is a data phase that ends with a request already waiting. Reaching it needs ready low and valid high on the same edge, right after a wait run. When it happens, the completion pulse, the read capture and the new address phase all land together.

The random stimulus drives ready and valid independently at about even odds, so this coincidence occurs often, and it also changes the request fields on every clock. Directed phases add two more patterns:
- a long wait run with a request pending;
- a stretch of unbroken back-to-back two-clock cycles.

// File: rtl/lbus_pkg.sv
// Shared types for the local bus cycle sequencer.
package lbus_pkg;

    // Bus cycle phase: idle, address phase (one clock), data/wait phase.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2
    } bstate_e;

endpackage

// File: rtl/lbus_fsm.sv
// Bus phase controller.
// Walks idle -> address -> data (with wait clocks) -> address or idle.
// Assumes requests arrive already aligned; takes no notice of request
// contents. Reset is synchronous and active low.
module lbus_fsm
    import lbus_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    req_valid,
    input  logic    ready_n,
    output bstate_e state,
    output logic    accept,
    output logic    load,
    output logic    finish
);

    bstate_e state_nx;

    // Decode the acceptance window and the cycle-end condition.
    always_comb begin
        finish = (state == ST_DATA) && !ready_n;
        accept = (state == ST_IDLE) || finish;
        load   = accept && req_valid;
    end

    // Next-phase selection.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req_valid) state_nx = ST_ADDR;
            ST_ADDR: state_nx = ST_DATA;
            ST_DATA: if (!ready_n) state_nx = req_valid ? ST_ADDR : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !req_valid) |=> (state == ST_IDLE));
    p_idle_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && req_valid) |=> (state == ST_ADDR));
    p_addr_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR) |=> (state == ST_DATA));
    p_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && ready_n) |=> (state == ST_DATA));
    p_chain_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && !ready_n && req_valid) |=> (state == ST_ADDR));
    p_end_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && !ready_n && !req_valid) |=> (state == ST_IDLE));

endmodule

// File: rtl/lbus_hold.sv
// Request payload register.
// Captures address, byte enables, direction and write data when a request
// is taken, and holds them for the whole cycle. Assumes load only pulses
// on the acceptance window.
module lbus_hold #(
    parameter int ADDR_W = 30,
    parameter int DATA_W = 32,
    parameter int BE_W   = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [BE_W-1:0]   in_be_n,
    input  logic              in_wr,
    input  logic [DATA_W-1:0] in_wdata,
    output logic [ADDR_W-1:0] out_addr,
    output logic [BE_W-1:0]   out_be_n,
    output logic              out_wr,
    output logic [DATA_W-1:0] out_wdata
);

    // Load the payload on acceptance, otherwise keep it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_addr  <= '0;
            out_be_n  <= '0;
            out_wr    <= 1'b0;
            out_wdata <= '0;
        end else if (load) begin
            out_addr  <= in_addr;
            out_be_n  <= in_be_n;
            out_wr    <= in_wr;
            out_wdata <= in_wdata;
        end
    end

    p_no_load_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(out_addr) && $stable(out_wdata) && $stable(out_wr)));

endmodule

// File: rtl/lbus_resp.sv
// Completion path.
// Registers a one-clock done pulse after each cycle end, and captures bus
// read data on read cycles. Assumes finish never fires on two clocks in a row.
module lbus_resp #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              finish,
    input  logic              is_read,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata
);

    // Pulse done and capture read data at the cycle-ending edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_done  <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_done <= finish;
            if (finish && is_read) rsp_rdata <= bus_rdata;
        end
    end

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

endmodule

// File: rtl/lbus_seq.sv
// Non-pipelined local bus cycle sequencer (top).
// Runs one aligned bus cycle per request, with a minimum of two clocks per
// cycle and direct chaining into the next cycle. Assumes the requester holds
// nothing for the block: fields are sampled only on the accepting edge.
module lbus_seq
    import lbus_pkg::*;
#(
    parameter int ADDR_W = 30,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W/8-1:0] req_be_n,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_accept,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              bus_ads_n,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W/8-1:0] bus_be_n,
    output logic              bus_wr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ready_n,
    input  logic [DATA_W-1:0] bus_rdata
);

    localparam int BE_W = DATA_W / 8;

    bstate_e state;
    logic    load;
    logic    finish;

    lbus_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .ready_n   (bus_ready_n),
        .state     (state),
        .accept    (req_accept),
        .load      (load),
        .finish    (finish)
    );

    lbus_hold #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .BE_W   (BE_W)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .in_addr   (req_addr),
        .in_be_n   (req_be_n),
        .in_wr     (req_write),
        .in_wdata  (req_wdata),
        .out_addr  (bus_addr),
        .out_be_n  (bus_be_n),
        .out_wr    (bus_wr),
        .out_wdata (bus_wdata)
    );

    lbus_resp #(
        .DATA_W (DATA_W)
    ) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .finish    (finish),
        .is_read   (!bus_wr),
        .bus_rdata (bus_rdata),
        .rsp_done  (rsp_done),
        .rsp_rdata (rsp_rdata)
    );

    // Strobe decode: low only in the address phase.
    always_comb bus_ads_n = (state != ST_ADDR);

    p_ads_one_clk_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ads_n |=> bus_ads_n);
    p_hold_in_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && bus_ready_n) |=>
            ($stable(bus_addr) && $stable(bus_be_n) && $stable(bus_wr) && $stable(bus_wdata)));
    p_done_follows_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> rsp_done);
    p_no_accept_in_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ads_n |-> !req_accept);

endmodule

// File: tb/test_lbus_seq.sv
module test_lbus_seq;

    localparam int AW = 30;
    localparam int DW = 32;
    localparam int BW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic [AW-1:0] req_addr;
    logic [BW-1:0] req_be_n;
    logic          req_write;
    logic [DW-1:0] req_wdata;
    logic          req_accept;
    logic          rsp_done;
    logic [DW-1:0] rsp_rdata;
    logic          bus_ads_n;
    logic [AW-1:0] bus_addr;
    logic [BW-1:0] bus_be_n;
    logic          bus_wr;
    logic [DW-1:0] bus_wdata;
    logic          bus_ready_n;
    logic [DW-1:0] bus_rdata;

    always #5 clk = ~clk;

    lbus_seq i_lbus_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_be_n(req_be_n), .req_write(req_write), .req_wdata(req_wdata),
        .req_accept(req_accept), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .bus_ads_n(bus_ads_n), .bus_addr(bus_addr), .bus_be_n(bus_be_n),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_ready_n(bus_ready_n),
        .bus_rdata(bus_rdata)
    );

    int checks = 0;
    int errors = 0;

    // Reference model state: 0 idle, 1 address phase, 2 data phase.
    int            m_st;
    logic [AW-1:0] m_addr;
    logic [BW-1:0] m_be;
    logic          m_wr;
    logic [DW-1:0] m_wd;
    logic          m_done;
    logic [DW-1:0] m_rd;
    string         m_tag;
    int            ads_lows;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Expected strobe level for a model phase.
    function automatic logic exp_ads(input int st);
        return (st != 1);
    endfunction

    // Expected acceptance for a model phase and ready level.
    function automatic logic exp_acc(input int st, input logic rdyn);
        return (st == 0) || (st == 2 && !rdyn);
    endfunction

    // One clock: drive at negedge, update model, check outputs at next negedge.
    task automatic step(input logic v, input logic rdyn);
        int prev;
        req_valid   = v;
        bus_ready_n = rdyn;
        req_addr    = AW'($urandom);
        req_be_n    = BW'($urandom);
        req_write   = 1'($urandom);
        req_wdata   = $urandom;
        bus_rdata   = $urandom;
        #1;
        chk(req_accept == exp_acc(m_st, rdyn), "R9", "req_accept",
            64'(req_accept), 64'(exp_acc(m_st, rdyn)));
        prev = m_st;
        if (!rst_n) begin
            m_st = 0; m_addr = '0; m_be = '0; m_wr = 1'b0; m_wd = '0;
            m_done = 1'b0; m_rd = '0; m_tag = "R1";
        end else begin
            m_done = 1'b0;
            case (m_st)
                0: begin
                    m_tag = "R2";
                    if (v) begin
                        m_st = 1; m_addr = req_addr; m_be = req_be_n;
                        m_wr = req_write; m_wd = req_wdata;
                    end
                end
                1: begin m_st = 2; m_tag = "R4"; end
                default: begin
                    if (rdyn) m_tag = "R5";
                    else begin
                        m_done = 1'b1;
                        if (!m_wr) m_rd = bus_rdata;
                        if (v) begin
                            m_tag = "R6"; m_st = 1; m_addr = req_addr;
                            m_be = req_be_n; m_wr = req_write; m_wd = req_wdata;
                        end else begin
                            m_tag = "R7"; m_st = 0;
                        end
                    end
                end
            endcase
        end
        @(negedge clk);
        if (!bus_ads_n) ads_lows++;
        chk(bus_ads_n == exp_ads(m_st), m_tag, "bus_ads_n R3",
            64'(bus_ads_n), 64'(exp_ads(m_st)));
        chk(bus_addr == m_addr && bus_be_n == m_be, m_tag, "addr/be R5",
            64'({bus_be_n, bus_addr}), 64'({m_be, m_addr}));
        chk(bus_wr == m_wr && bus_wdata == m_wd, m_tag, "wr/wdata R5",
            64'({bus_wr, bus_wdata}), 64'({m_wr, m_wd}));
        chk(rsp_done == m_done, "R8", "rsp_done", 64'(rsp_done), 64'(m_done));
        chk(rsp_rdata == m_rd, "R8", "rsp_rdata", 64'(rsp_rdata), 64'(m_rd));
        if (prev == 1) ; // R4 covered through m_tag above
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        m_st = 0; m_addr = '0; m_be = '0; m_wr = 1'b0; m_wd = '0;
        m_done = 1'b0; m_rd = '0; m_tag = "R1"; ads_lows = 0;
        rst_n = 1'b0;
        req_valid = 1'b0; req_addr = '0; req_be_n = '0; req_write = 1'b0;
        req_wdata = '0; bus_ready_n = 1'b1; bus_rdata = '0;
        @(negedge clk);
        // R1: reset holds the block idle even with requests offered.
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
        chk(bus_ads_n == 1'b1 && rsp_done == 1'b0 && bus_addr == '0, "R1",
            "reset state", 64'({bus_ads_n, rsp_done}), 64'(2'b10));
        rst_n = 1'b1;

        // R2: idle with no request stays idle.
        for (int i = 0; i < 4; i++) step(1'b0, 1'($urandom));

        // Random mix of requests and wait states.
        for (int i = 0; i < 3000; i++)
            step(($urandom % 10) < 6, ($urandom % 2) == 0);

        // R5: long wait run with a request pending and changing fields.
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0);
        step(1'b1, 1'b1);
        for (int i = 0; i < 25; i++) step(1'b1, 1'b1);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);

        // R10: back-to-back two-clock cycles from idle.
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0);
        ads_lows = 0;
        for (int i = 0; i < 12; i++) step(1'b1, 1'b0);
        chk(ads_lows == 6, "R10", "strobes in 12 clocks", 64'(ads_lows), 64'd6);

        // R1: reset in the middle of a cycle.
        step(1'b1, 1'b1);
        rst_n = 1'b0;
        step(1'b1, 1'b1);
        rst_n = 1'b1;

        // Random again, skewed toward slow slaves.
        for (int i = 0; i < 1000; i++)
            step(($urandom % 10) < 7, ($urandom % 4) != 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule